// File: doc/BRIEF.md
# Word-Serial AES-128 Encryption Core

This block encrypts a single 128-bit block under a 128-bit key with AES-128. It keeps the pin count low. Plaintext, key and ciphertext all cross the boundary as four 32-bit words, and the round logic works on one 32-bit state column per clock. A host drives plaintext and key words together on two 32-bit buses while it holds the load enable. After the fourth word the core raises busy and runs ten rounds in forty clocks. It then presents the ciphertext as four consecutive words under a valid strobe. Busy drops together with the last output word. A new block can then be loaded at once.

The first word on each bus is the most significant 32 bits of the 128-bit value, which is state column 0. Within a word, the most significant byte comes first in AES byte order. The initial key addition happens while the words are loaded. Each following round computes one column per clock: substitution, row shift, column mixing (skipped in round ten) and round-key XOR. The round key is expanded one word per clock alongside the columns. A round's four result columns are staged and written into the state only after the fourth one is done.

Top module: `aesw_core`

## Requirements
- R1: The block accepts a plaintext word and a key word on each clock where ldEn is high and busy is low. Four such words form a block, and low cycles between them are allowed. The first word is bits 127:96, which is column 0, with bits 31:24 of a word as the first byte of that column.
- R2: busy rises in the cycle after the fourth word is accepted. It stays high for exactly 44 cycles and falls in the same cycle as ctValid.
- R3: While busy is high, ldEn, dataIn and keyIn have no effect. The ciphertext of the running block is unchanged, and none of those words counts toward the next block.
- R4: The four output words, concatenated first word in the most significant position, equal the AES-128 encryption of the loaded plaintext under the loaded key.
- R5: ctValid rises exactly 40 cycles after busy rises and stays high for exactly 4 consecutive cycles. The first valid word is ciphertext bits 127:96.
- R6: ctOut is all zeros in every cycle where ctValid is low.
- R7: A block may be loaded starting in the first cycle where busy is low again. Each block is encrypted independently of the one before it.
- R8: While rstN is low, busy, ctValid and ctOut are 0. Any partly loaded block is discarded by a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ldEn | input | 1 | Load enable; one plaintext and key word accepted per high cycle while idle |
| dataIn | input | 32 | Plaintext word |
| keyIn | input | 32 | Key word |
| busy | output | 1 | High from the cycle after the fourth input word until the last output word |
| ctOut | output | 32 | Ciphertext word, zero when not valid |
| ctValid | output | 1 | High for the four ciphertext word cycles |

## Verification
The core is exercised with three known-answer pairs. The first has an all-zero key and plaintext. The second has counting byte patterns in key and plaintext. The third mixes bytes with high and low bits set. Together they separate errors in substitution, row shift direction, column mixing and round-constant sequencing, because any one of these changes every output word. A run with idle gaps between input words shows that only enabled cycles count. Junk words driven during processing and output, followed by a clean block, show that nothing is taken while busy. Back-to-back blocks and a reset in the middle of a load show that no state carries over between blocks.

// File: rtl/aesw_pkg.sv
package aesw_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 4;
  localparam int BLK_W   = WORD_W * NWORDS;
  localparam int NROUNDS = 10;
  localparam int COL_W   = $clog2(NWORDS);
  localparam int RND_W   = $clog2(NROUNDS + 1);
  localparam int BYTES_W = WORD_W / BYTE_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             ldWord;   // shift one input word in
    logic             step;     // compute one column of a round
    logic [COL_W-1:0] colIdx;   // column being computed
    logic             colZero;  // first column of a round
    logic             colLast;  // last column of a round
    logic             finalRnd; // round without column mixing
    logic             emit;     // present and shift out one ciphertext word
  } ctrlStrb_t;

  function automatic logic [BYTE_W-1:0] gfXtime(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [BYTE_W-1:0] gfMul(input logic [BYTE_W-1:0] a,
                                              input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfXtime(sh);
    end
    return acc;
  endfunction

  // substitution: multiplicative inverse (x^254) followed by the affine map
  function automatic logic [BYTE_W-1:0] sboxByte(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] pw;
    logic [BYTE_W-1:0] inv;
    pw  = x;
    inv = 8'h01;
    for (int k = 0; k < 7; k++) begin
      pw  = gfMul(pw, pw);
      inv = gfMul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [WORD_W-1:0] mixColumn(input logic [WORD_W-1:0] c);
    logic [BYTE_W-1:0] a0, a1, a2, a3;
    logic [BYTE_W-1:0] d0, d1, d2, d3;
    a0 = c[31:24];
    a1 = c[23:16];
    a2 = c[15:8];
    a3 = c[7:0];
    d0 = gfXtime(a0) ^ gfXtime(a1) ^ a1 ^ a2 ^ a3;
    d1 = a0 ^ gfXtime(a1) ^ gfXtime(a2) ^ a2 ^ a3;
    d2 = a0 ^ a1 ^ gfXtime(a2) ^ gfXtime(a3) ^ a3;
    d3 = gfXtime(a0) ^ a0 ^ a1 ^ a2 ^ gfXtime(a3);
    return {d0, d1, d2, d3};
  endfunction

endpackage

// File: rtl/aesw_sbox4.sv
module aesw_sbox4
  import aesw_pkg::*;
#(
  parameter int LANES = BYTES_W
) (
  input  logic [LANES*BYTE_W-1:0] sbIn,
  output logic [LANES*BYTE_W-1:0] sbOut
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign sbOut[g*BYTE_W +: BYTE_W] = sboxByte(sbIn[g*BYTE_W +: BYTE_W]);
  end

endmodule

// File: rtl/aesw_ctrl.sv
module aesw_ctrl
  import aesw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ldEn,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      ctValid
);

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_OUT} phase_t;

  localparam logic [COL_W-1:0] CNT_LAST = COL_W'(NWORDS - 1);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NROUNDS);
  localparam logic [RND_W-1:0] RND_ONE  = RND_W'(1);

  phase_t           phase;
  logic [COL_W-1:0] cnt;
  logic [RND_W-1:0] rnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rnd   <= RND_ONE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (ldEn) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) begin
              phase <= PH_RUN;
              rnd   <= RND_ONE;
            end
          end
        end
        PH_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            if (rnd == RND_LAST) phase <= PH_OUT;
            else                 rnd   <= rnd + 1'b1;
          end
        end
        PH_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.ldWord   = (phase == PH_IDLE) && ldEn;
    strb.step     = (phase == PH_RUN);
    strb.colIdx   = cnt;
    strb.colZero  = (cnt == '0);
    strb.colLast  = (cnt == CNT_LAST);
    strb.finalRnd = (rnd == RND_LAST);
    strb.emit     = (phase == PH_OUT);
  end

  assign busy    = (phase != PH_IDLE);
  assign ctValid = (phase == PH_OUT);

endmodule

// File: rtl/aesw_dpath.sv
module aesw_dpath
  import aesw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] keyIn,
  output logic [WORD_W-1:0] ctOut
);

  localparam int STAGE_W = BLK_W - WORD_W;

  logic [BLK_W-1:0]   stateReg;  // current round state, column 0 in the top word
  logic [BLK_W-1:0]   keyReg;    // sliding window of the last four key words
  logic [STAGE_W-1:0] stageReg;  // finished columns of the round in progress
  logic [BYTE_W-1:0]  rcon;

  logic [WORD_W-1:0] colIn, colSub, colMix, colOut;
  logic [WORD_W-1:0] rotWord, rotSub, keyWord;

  // row shift folded into the column gather: row r comes from column colIdx+r
  always_comb begin
    colIn = '0;
    for (int r = 0; r < BYTES_W; r++) begin
      colIn[WORD_W-1-BYTE_W*r -: BYTE_W] =
        stateReg[BLK_W-1-WORD_W*((int'(strb.colIdx) + r) % NWORDS)-BYTE_W*r -: BYTE_W];
    end
  end

  aesw_sbox4 u_sbCol (.sbIn(colIn),   .sbOut(colSub));
  aesw_sbox4 u_sbKey (.sbIn(rotWord), .sbOut(rotSub));

  assign colMix  = strb.finalRnd ? colSub : mixColumn(colSub);
  assign rotWord = {keyReg[WORD_W-BYTE_W-1:0], keyReg[WORD_W-1 -: BYTE_W]};
  assign keyWord = keyReg[BLK_W-1 -: WORD_W] ^
                   (strb.colZero ? (rotSub ^ {rcon, {(WORD_W-BYTE_W){1'b0}}})
                                 : keyReg[WORD_W-1:0]);
  assign colOut  = colMix ^ keyWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= '0;
      keyReg   <= '0;
      stageReg <= '0;
      rcon     <= 8'h01;
    end else if (strb.ldWord) begin
      stateReg <= {stateReg[STAGE_W-1:0], dataIn ^ keyIn};
      keyReg   <= {keyReg[STAGE_W-1:0], keyIn};
      rcon     <= 8'h01;
    end else if (strb.step) begin
      keyReg <= {keyReg[STAGE_W-1:0], keyWord};
      if (strb.colLast) begin
        stateReg <= {stageReg, colOut};
        rcon     <= gfXtime(rcon);
      end else begin
        stageReg <= {stageReg[STAGE_W-WORD_W-1:0], colOut};
      end
    end else if (strb.emit) begin
      stateReg <= {stateReg[STAGE_W-1:0], {WORD_W{1'b0}}};
    end
  end

  assign ctOut = strb.emit ? stateReg[BLK_W-1 -: WORD_W] : '0;

endmodule

// File: rtl/aesw_core.sv
module aesw_core
  import aesw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] keyIn,
  output logic              busy,
  output logic [WORD_W-1:0] ctOut,
  output logic              ctValid
);

  ctrlStrb_t strb;

  aesw_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ldEn    (ldEn),
    .strb    (strb),
    .busy    (busy),
    .ctValid (ctValid)
  );

  aesw_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dataIn (dataIn),
    .keyIn  (keyIn),
    .ctOut  (ctOut)
  );

endmodule

// File: rtl/aesw_core_chk.sv
module aesw_core_chk
  import aesw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ldEn,
  input logic              busy,
  input logic              ctValid,
  input logic [WORD_W-1:0] ctOut
);

  logic [7:0] busyLen;
  logic [7:0] validLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen  <= '0;
      validLen <= '0;
    end else begin
      busyLen  <= busy    ? busyLen + 8'd1  : 8'd0;
      validLen <= ctValid ? validLen + 8'd1 : 8'd0;
    end
  end

  assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ldEn));

  assert_valid_in_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctValid |-> busy);

  assert_busy_span_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 8'd44));

  assert_end_together_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctValid) |-> !busy);

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctValid) |-> (busyLen == 8'd40));

  assert_valid_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctValid) |-> (validLen == 8'd4));

  assert_out_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctValid |-> (ctOut == '0));

endmodule

bind aesw_core aesw_core_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ldEn    (ldEn),
  .busy    (busy),
  .ctValid (ctValid),
  .ctOut   (ctOut)
);

// File: tb/aesw_core_tb.sv
module aesw_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] keyIn = '0;
  logic        busy;
  logic [31:0] ctOut;
  logic        ctValid;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  aesw_core u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .ldEn    (ldEn),
    .dataIn  (dataIn),
    .keyIn   (keyIn),
    .busy    (busy),
    .ctOut   (ctOut),
    .ctValid (ctValid)
  );

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // drives words starting at the current negedge; returns at the negedge
  // after the fourth word was taken
  task automatic loadBlock(input logic [127:0] pt, input logic [127:0] key,
                           input int gapAt);
    for (int w = 0; w < 4; w++) begin
      if (w == gapAt) begin
        ldEn   = 1'b0;
        dataIn = 32'hdead_beef;
        keyIn  = 32'hfeed_f00d;
        repeat (3) @(negedge clk);
      end
      ldEn   = 1'b1;
      dataIn = pt[127-32*w -: 32];
      keyIn  = key[127-32*w -: 32];
      @(negedge clk);
    end
    ldEn = 1'b0;
  endtask

  // one block end to end; junk=1 drives load requests while busy
  task automatic runBlock(input logic [127:0] pt, input logic [127:0] key,
                          input logic [127:0] exp, input int gapAt,
                          input bit junk, input string tag);
    logic [127:0] ct;
    int lat;
    loadBlock(pt, key, gapAt);
    check(busy == 1'b1, "R2", {tag, " busy after fourth word"}, 128'(busy), 128'd1);
    lat = 0;
    while (!ctValid && lat < 100) begin
      if (lat == 7)
        check(ctOut == 32'h0, "R6", {tag, " output quiet while running"}, 128'(ctOut), 128'd0);
      @(negedge clk);
      lat++;
      ldEn   = junk && (lat < 30);
      dataIn = 32'h1357_9bdf ^ 32'(lat);
      keyIn  = 32'h2468_ace0 ^ 32'(lat * 3);
    end
    check(lat == 40, "R5", {tag, " cycles from busy to valid"}, 128'(lat), 128'd40);
    ct = '0;
    for (int k = 0; k < 4; k++) begin
      ldEn = junk && (k < 3);
      check(ctValid == 1'b1, "R5", {tag, " valid held"}, 128'(ctValid), 128'd1);
      ct[127-32*k -: 32] = ctOut;
      @(negedge clk);
    end
    ldEn = 1'b0;
    check(ct == exp, junk ? "R3" : "R4", {tag, " ciphertext"}, ct, exp);
    check(!busy && !ctValid, "R2", {tag, " busy and valid end together"},
          128'({busy, ctValid}), 128'd0);
    check(ctOut == 32'h0, "R6", {tag, " output quiet after block"}, 128'(ctOut), 128'd0);
  endtask

  localparam logic [127:0] K0 = 128'h0;
  localparam logic [127:0] P0 = 128'h0;
  localparam logic [127:0] C0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

  task automatic testReset();  // R8
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy in reset", 128'(busy), 128'd0);
    check(ctValid == 1'b0, "R8", "valid in reset", 128'(ctValid), 128'd0);
    check(ctOut == 32'h0, "R8", "output in reset", 128'(ctOut), 128'd0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testVectors();  // R4, R1 ordering
    runBlock(P1, K1, C1, -1, 1'b0, "R4 counting vector");
    repeat (2) @(negedge clk);
    runBlock(P0, K0, C0, -1, 1'b0, "R4 zero vector");
    repeat (2) @(negedge clk);
    runBlock(P2, K2, C2, -1, 1'b0, "R4 mixed vector");
  endtask

  task automatic testGaps();  // R1
    repeat (2) @(negedge clk);
    runBlock(P2, K2, C2, 2, 1'b0, "R1 gap before third word");
    repeat (1) @(negedge clk);
    runBlock(P1, K1, C1, 1, 1'b0, "R1 gap before second word");
  endtask

  task automatic testIgnoreBusy();  // R3
    repeat (2) @(negedge clk);
    runBlock(P1, K1, C1, -1, 1'b1, "R3 junk while busy");
    runBlock(P0, K0, C0, -1, 1'b0, "R3 clean block after junk");
  endtask

  task automatic testBackToBack();  // R7
    runBlock(P2, K2, C2, -1, 1'b0, "R7 first of pair");
    runBlock(P1, K1, C1, -1, 1'b0, "R7 second loaded at once");
    runBlock(P2, K2, C2, -1, 1'b0, "R7 third repeats first");
  endtask

  task automatic testResetMidLoad();  // R8
    repeat (2) @(negedge clk);
    ldEn   = 1'b1;
    dataIn = 32'hffff_ffff;
    keyIn  = 32'haaaa_5555;
    repeat (2) @(negedge clk);
    ldEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy after mid-load reset", 128'(busy), 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    runBlock(P1, K1, C1, -1, 1'b0, "R8 block after mid-load reset");
  endtask

  initial begin : main
    testReset();
    testVectors();
    testGaps();
    testIgnoreBusy();
    testBackToBack();
    testResetMidLoad();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule